// File: doc/BRIEF.md
# Shared-Bus Wishbone Interconnect

This block lets four bus masters reach three slaves over a single shared Wishbone path. A rotating-priority arbiter hands the shared path to one master at a time. The winner's address, write data, byte selects and write enable drive one common set of slave-side wires that every slave sees. Each slave also gets its own cycle and strobe. These two are gated by an address decoder, which compares the top bits of the word address against a fixed value per slave.

The return path takes read data and acknowledge from whichever slave the decoder picked. Read data is broadcast to every master. Acknowledge goes only to the master that holds the grant. A master keeps the bus for as long as it holds its cycle signal high. Because of this, a master can run several transfers back to back inside one cycle. When the cycle ends, the bus moves to the next requester in rotating order.

Top module: `shbus_fabric`

## Requirements
- R1: While reset is high, and in the first cycle after it, no slave cycle, slave strobe or master acknowledge is active. With all four masters requesting right after reset, master 0 is served first.
- R2: When the owning master drops its cycle signal, the grant passes to the first requesting master found by counting upward from the previous owner and wrapping from master 3 back to master 0.
- R3: Once a master is granted, the grant stays with it for as long as its cycle signal stays high. Requests from other masters during that time do not change the shared address or the slave cycle signals.
- R4: The 3-bit segment is address bits [29:27]. Only segments 0, 1 and 3 are mapped. Any other segment (2, 4, 5, 6, 7) raises no slave cycle or strobe and produces no acknowledge, however long the master waits.
- R5: Segment 0 selects slave 0, segment 1 selects slave 1 and segment 3 selects slave 2. Only the selected slave sees cycle and strobe. The shared address, write data, byte selects and write enable carry the owning master's values.
- R6: Master read data equals the selected slave's read data. The selected slave's acknowledge reaches only the owning master, and every other master sees acknowledge low.
- R7: The grant is registered. A request first shows on the slave side after the next rising clock edge. Once granted, the request and response paths add no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_adr | input | 4x30 | Word address per master |
| m_dat_w | input | 4x32 | Write data per master |
| m_sel | input | 4x4 | Byte selects per master |
| m_we | input | 4 | Write enable per master |
| m_cyc | input | 4 | Cycle (bus request) per master |
| m_stb | input | 4 | Strobe per master |
| m_dat_r | output | 32 | Read data, common to all masters |
| m_ack | output | 4 | Acknowledge per master |
| s_adr | output | 30 | Shared word address |
| s_dat_w | output | 32 | Shared write data |
| s_sel | output | 4 | Shared byte selects |
| s_we | output | 1 | Shared write enable |
| s_cyc | output | 3 | Decoded cycle per slave |
| s_stb | output | 3 | Decoded strobe per slave |
| s_dat_r | input | 3x32 | Read data per slave |
| s_ack | input | 3 | Acknowledge per slave |

## Verification
Several properties are checked on every cycle:
- At most one slave is ever in a cycle.
- An unmapped segment never raises a slave cycle.
- An acknowledge only ever reaches the current owner.
- An owner that holds its cycle keeps the grant.
- A grant only appears after a request.

Some behaviours only the bench's scenarios can show. These are the exact rotating order over every request mask, the read data and stored write values for each slave, the one-edge grant latency, and the absence of an acknowledge on unmapped accesses over a long wait.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
  localparam int DEF_MST     = 4;
  localparam int DEF_SLV     = 3;
  localparam int DEF_ADR_W   = 30;
  localparam int DEF_DAT_W   = 32;
  localparam int DEF_SEG_LSB = 27;

  typedef enum logic {ARB_IDLE, ARB_HELD} arb_state_e;

  // position reached by stepping off places upward from v, modulo n
  function automatic int wrap_inc(int v, int off, int n);
    return (v + off) % n;
  endfunction
endpackage

// File: rtl/shbus_rr_arb.sv
module shbus_rr_arb
  import shbus_pkg::*;
#(
  parameter int N  = DEF_MST,
  parameter int IW = $clog2(DEF_MST)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [IW-1:0] owner,
  output logic          held
);
  arb_state_e    st;
  logic [IW-1:0] own_q;
  logic [IW-1:0] nxt;
  logic          any;

  // closest requester after the previous owner wins (descending scan, last hit kept)
  always_comb begin
    nxt = own_q;
    any = 1'b0;
    for (int off = N; off >= 1; off--) begin
      if (req[wrap_inc(int'(own_q), off, N)]) begin
        nxt = IW'(wrap_inc(int'(own_q), off, N));
        any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ARB_IDLE;
      own_q <= IW'(N - 1);   // so that master 0 comes first
    end else if (!(st == ARB_HELD && req[own_q])) begin
      if (any) begin
        st    <= ARB_HELD;
        own_q <= nxt;
      end else begin
        st    <= ARB_IDLE;
      end
    end
  end

  assign owner = own_q;
  assign held  = (st == ARB_HELD);
endmodule

// File: rtl/shbus_mst_mux.sv
module shbus_mst_mux #(
  parameter int N     = 4,
  parameter int IW    = 2,
  parameter int ADR_W = 30,
  parameter int DAT_W = 32,
  parameter int SEL_W = 4
) (
  input  logic [N-1:0][ADR_W-1:0] m_adr,
  input  logic [N-1:0][DAT_W-1:0] m_dat_w,
  input  logic [N-1:0][SEL_W-1:0] m_sel,
  input  logic [N-1:0]            m_we,
  input  logic [N-1:0]            m_cyc,
  input  logic [N-1:0]            m_stb,
  input  logic [IW-1:0]           owner,
  input  logic                    held,
  output logic [ADR_W-1:0]        sh_adr,
  output logic [DAT_W-1:0]        sh_dat_w,
  output logic [SEL_W-1:0]        sh_sel,
  output logic                    sh_we,
  output logic                    sh_cyc,
  output logic                    sh_stb
);
  always_comb begin
    sh_adr   = m_adr[owner];
    sh_dat_w = m_dat_w[owner];
    sh_sel   = m_sel[owner];
    sh_we    = held & m_we[owner];
    sh_cyc   = held & m_cyc[owner];
    sh_stb   = held & m_cyc[owner] & m_stb[owner];
  end
endmodule

// File: rtl/shbus_slv_dec.sv
module shbus_slv_dec #(
  parameter int NS        = 3,
  parameter int ADR_W     = 30,
  parameter int DAT_W     = 32,
  parameter int SEG_LSB   = 27,
  parameter int SLV_MATCH [NS] = '{0, 1, 3}
) (
  input  logic [ADR_W-1:0]        sh_adr,
  input  logic                    sh_cyc,
  input  logic                    sh_stb,
  input  logic [NS-1:0][DAT_W-1:0] s_dat_r,
  input  logic [NS-1:0]           s_ack,
  output logic [NS-1:0]           s_cyc,
  output logic [NS-1:0]           s_stb,
  output logic [DAT_W-1:0]        rd_dat,
  output logic                    rd_ack
);
  localparam int SEG_W = ADR_W - SEG_LSB;

  logic [SEG_W-1:0] seg;
  logic [NS-1:0]    hit;

  assign seg = sh_adr[ADR_W-1:SEG_LSB];

  for (genvar k = 0; k < NS; k++) begin : g_slot
    assign hit[k]   = (seg == SEG_W'(SLV_MATCH[k]));
    assign s_cyc[k] = sh_cyc & hit[k];
    assign s_stb[k] = sh_stb & hit[k];
  end

  always_comb begin
    rd_dat = '0;
    rd_ack = 1'b0;
    for (int k = 0; k < NS; k++) begin
      if (hit[k]) begin
        rd_dat = s_dat_r[k];
        rd_ack = sh_cyc & s_ack[k];
      end
    end
  end
endmodule

// File: rtl/shbus_fabric.sv
module shbus_fabric
  import shbus_pkg::*;
#(
  parameter int NUM_MST   = DEF_MST,
  parameter int NUM_SLV   = DEF_SLV,
  parameter int ADR_W     = DEF_ADR_W,
  parameter int DAT_W     = DEF_DAT_W,
  parameter int SEG_LSB   = DEF_SEG_LSB,
  parameter int SLV_MATCH [NUM_SLV] = '{0, 1, 3}
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_MST-1:0][ADR_W-1:0]  m_adr,
  input  logic [NUM_MST-1:0][DAT_W-1:0]  m_dat_w,
  input  logic [NUM_MST-1:0][DAT_W/8-1:0] m_sel,
  input  logic [NUM_MST-1:0]             m_we,
  input  logic [NUM_MST-1:0]             m_cyc,
  input  logic [NUM_MST-1:0]             m_stb,
  output logic [DAT_W-1:0]               m_dat_r,
  output logic [NUM_MST-1:0]             m_ack,
  output logic [ADR_W-1:0]               s_adr,
  output logic [DAT_W-1:0]               s_dat_w,
  output logic [DAT_W/8-1:0]             s_sel,
  output logic                           s_we,
  output logic [NUM_SLV-1:0]             s_cyc,
  output logic [NUM_SLV-1:0]             s_stb,
  input  logic [NUM_SLV-1:0][DAT_W-1:0]  s_dat_r,
  input  logic [NUM_SLV-1:0]             s_ack
);
  localparam int SEL_W = DAT_W / 8;
  localparam int IW    = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;

  logic [IW-1:0] gnt_idx;
  logic          gnt_held;
  logic          sh_cyc, sh_stb, rd_ack;

  shbus_rr_arb #(.N(NUM_MST), .IW(IW)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req   (m_cyc),
    .owner (gnt_idx),
    .held  (gnt_held)
  );

  shbus_mst_mux #(
    .N(NUM_MST), .IW(IW), .ADR_W(ADR_W), .DAT_W(DAT_W), .SEL_W(SEL_W)
  ) u_mux (
    .m_adr    (m_adr),
    .m_dat_w  (m_dat_w),
    .m_sel    (m_sel),
    .m_we     (m_we),
    .m_cyc    (m_cyc),
    .m_stb    (m_stb),
    .owner    (gnt_idx),
    .held     (gnt_held),
    .sh_adr   (s_adr),
    .sh_dat_w (s_dat_w),
    .sh_sel   (s_sel),
    .sh_we    (s_we),
    .sh_cyc   (sh_cyc),
    .sh_stb   (sh_stb)
  );

  shbus_slv_dec #(
    .NS(NUM_SLV), .ADR_W(ADR_W), .DAT_W(DAT_W), .SEG_LSB(SEG_LSB),
    .SLV_MATCH(SLV_MATCH)
  ) u_dec (
    .sh_adr  (s_adr),
    .sh_cyc  (sh_cyc),
    .sh_stb  (sh_stb),
    .s_dat_r (s_dat_r),
    .s_ack   (s_ack),
    .s_cyc   (s_cyc),
    .s_stb   (s_stb),
    .rd_dat  (m_dat_r),
    .rd_ack  (rd_ack)
  );

  // acknowledge steered to the owner only
  for (genvar i = 0; i < NUM_MST; i++) begin : g_ack
    assign m_ack[i] = gnt_held & rd_ack & (gnt_idx == IW'(i));
  end
endmodule

// File: rtl/shbus_fabric_chk.sv
module shbus_fabric_chk #(
  parameter int NUM_MST   = 4,
  parameter int NUM_SLV   = 3,
  parameter int SEG_W     = 3,
  parameter int IW        = 2,
  parameter int SLV_MATCH [NUM_SLV] = '{0, 1, 3}
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_MST-1:0] m_cyc,
  input logic [NUM_MST-1:0] m_ack,
  input logic [NUM_SLV-1:0] s_cyc,
  input logic [SEG_W-1:0]   s_seg,
  input logic [IW-1:0]      gnt_idx,
  input logic               gnt_held
);
  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int k = 0; k < NUM_SLV; k++)
      if (s_seg == SEG_W'(SLV_MATCH[k])) mapped = 1'b1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !gnt_held |-> (s_cyc == '0 && m_ack == '0));

  p_hold_grant_r3: assert property (@(posedge clk) disable iff (rst)
    (gnt_held && m_cyc[gnt_idx]) |=> (gnt_held && gnt_idx == $past(gnt_idx)));

  p_unmapped_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> (s_cyc == '0));

  p_one_slave_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_cyc));

  p_ack_owner_r6: assert property (@(posedge clk) disable iff (rst)
    (|m_ack) |-> ($countones(m_ack) == 1 && gnt_held && m_ack[gnt_idx]));

  p_grant_after_req_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_held) |-> $past(|m_cyc));
endmodule

bind shbus_fabric shbus_fabric_chk #(
  .NUM_MST(NUM_MST), .NUM_SLV(NUM_SLV), .SEG_W(ADR_W - SEG_LSB), .IW(IW),
  .SLV_MATCH(SLV_MATCH)
) i_fabric_chk (
  .clk      (clk),
  .rst      (rst),
  .m_cyc    (m_cyc),
  .m_ack    (m_ack),
  .s_cyc    (s_cyc),
  .s_seg    (s_adr[ADR_W-1:SEG_LSB]),
  .gnt_idx  (gnt_idx),
  .gnt_held (gnt_held)
);

// File: tb/test_shbus_fabric.sv
module test_shbus_fabric;
  localparam int NM = 4;
  localparam int NS = 3;
  localparam int AW = 30;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [NM-1:0][AW-1:0] m_adr;
  logic [NM-1:0][DW-1:0] m_dat_w;
  logic [NM-1:0][3:0]    m_sel;
  logic [NM-1:0]         m_we, m_cyc, m_stb;
  logic [DW-1:0]         m_dat_r;
  logic [NM-1:0]         m_ack;
  logic [AW-1:0]         s_adr;
  logic [DW-1:0]         s_dat_w;
  logic [3:0]            s_sel;
  logic                  s_we;
  logic [NS-1:0]         s_cyc, s_stb;
  logic [NS-1:0][DW-1:0] s_dat_r;
  logic [NS-1:0]         s_ack;

  shbus_fabric i_shbus_fabric (
    .clk(clk), .rst(rst),
    .m_adr(m_adr), .m_dat_w(m_dat_w), .m_sel(m_sel), .m_we(m_we),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_dat_r(m_dat_r), .m_ack(m_ack),
    .s_adr(s_adr), .s_dat_w(s_dat_w), .s_sel(s_sel), .s_we(s_we),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_dat_r(s_dat_r), .s_ack(s_ack)
  );

  // slave models: one-cycle registered ack, read data = {slave id, address}
  logic [NS-1:0]         ack_q;
  logic [NS-1:0][DW-1:0] wdat;
  logic [NS-1:0][3:0]    wsel;
  assign s_ack = ack_q;
  always_comb for (int k = 0; k < NS; k++) s_dat_r[k] = {2'(k), s_adr};
  always @(posedge clk) begin
    for (int k = 0; k < NS; k++) begin
      if (rst) ack_q[k] <= 1'b0;
      else begin
        ack_q[k] <= s_cyc[k] & s_stb[k] & ~ack_q[k];
        if (s_cyc[k] && s_stb[k] && !ack_q[k] && s_we) begin
          wdat[k] <= s_dat_w;
          wsel[k] <= s_sel;
        end
      end
    end
  end

  int total = 0;
  int bad   = 0;
  int mdl_last = NM - 1;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pick(int last, logic [NM-1:0] m);
    for (int off = 1; off <= NM; off++)
      if (m[(last + off) % NM]) return (last + off) % NM;
    return -1;
  endfunction

  function automatic logic [2:0] seg_of(int k);
    return (k == 2) ? 3'd3 : 3'(k);
  endfunction

  function automatic int slv_for(int i, logic [NM-1:0] mask);
    return (i + int'(mask)) % NS;
  endfunction

  task automatic set_master(int i, logic [2:0] seg, logic [26:0] low, logic we,
                            logic [31:0] d, logic [3:0] sel);
    m_adr[i] = {seg, low}; m_dat_w[i] = d; m_sel[i] = sel; m_we[i] = we;
    m_cyc[i] = 1'b1; m_stb[i] = 1'b1;
  endtask

  task automatic drop(int i);
    m_cyc[i] = 1'b0; m_stb[i] = 1'b0; m_we[i] = 1'b0;
  endtask

  task automatic run_round(logic [NM-1:0] mask);
    logic [NM-1:0] rem;
    int exp, guard, a, k;
    bit first;
    @(negedge clk);
    for (int i = 0; i < NM; i++)
      if (mask[i])
        set_master(i, seg_of(slv_for(i, mask)), 27'(i * 1000 + int'(mask) * 7 + 5),
                   ((i + int'(mask)) % 2) == 1, 32'h5A00_0000 ^ (32'(mask) << 8) ^ 32'(i),
                   4'(1 << ((i + int'(mask)) % 4)) | 4'h1);
    rem = mask; exp = pick(mdl_last, rem); guard = 0; first = 1;
    while (rem != 0 && guard < 200) begin
      @(negedge clk); guard++;
      if (|s_cyc && exp >= 0) begin
        chk(s_cyc == 3'(1 << slv_for(exp, mask)), "R5", "slave cycle", 64'(s_cyc),
            64'(1 << slv_for(exp, mask)));
        chk(s_adr == m_adr[exp], "R3", "shared address", 64'(s_adr), 64'(m_adr[exp]));
      end
      if (|m_ack) begin
        chk(m_ack == 4'(1 << exp), (mask == 4'hF && first) ? "R1" : "R2",
            "grant order", 64'(m_ack), 64'(1 << exp));
        first = 0;
        a = 0;
        for (int i = NM - 1; i >= 0; i--) if (m_ack[i]) a = i;
        k = slv_for(a, mask);
        if (m_we[a]) begin
          chk(wdat[k] == m_dat_w[a], "R5", "written data", 64'(wdat[k]), 64'(m_dat_w[a]));
          chk(wsel[k] == m_sel[a], "R5", "written selects", 64'(wsel[k]), 64'(m_sel[a]));
        end else begin
          chk(m_dat_r == {2'(k), m_adr[a]}, "R6", "read data", 64'(m_dat_r),
              64'({2'(k), m_adr[a]}));
        end
        drop(a); rem[a] = 1'b0; mdl_last = a; exp = pick(mdl_last, rem);
      end
    end
    if (guard >= 200) chk(0, "R2", "round timeout", 64'(rem), 64'(0));
  endtask

  initial begin
    m_adr = '0; m_dat_w = '0; m_sel = '0; m_we = '0; m_cyc = '0; m_stb = '0;
    m_cyc[3] = 1'b1; m_stb[3] = 1'b1;           // request during reset is ignored
    repeat (3) @(negedge clk);
    chk(s_cyc == 0 && s_stb == 0 && m_ack == 0, "R1", "quiet in reset",
        64'({s_cyc, s_stb, m_ack}), 64'(0));
    drop(3);
    rst = 1'b0;
    @(negedge clk);
    chk(s_cyc == 0 && m_ack == 0, "R1", "quiet after reset", 64'({s_cyc, m_ack}), 64'(0));

    // every request mask, full set first (R1 first grant, R2 rotation)
    for (int m = 15; m >= 1; m--) run_round(4'(m));

    // R7 latency and R3 hold against a competing request
    @(negedge clk);
    @(negedge clk);
    set_master(2, 3'd1, 27'h123, 1'b0, 32'h0, 4'hF);
    #1 chk(s_cyc == 0, "R7", "no grant before edge", 64'(s_cyc), 64'(0));
    @(negedge clk);
    chk(s_cyc == 3'b010, "R7", "grant after one edge", 64'(s_cyc), 64'(3'b010));
    chk(m_ack == 0, "R7", "no ack yet", 64'(m_ack), 64'(0));
    set_master(0, 3'd0, 27'h777, 1'b0, 32'h0, 4'hF);
    #1;
    chk(s_adr == {3'd1, 27'h123}, "R3", "owner keeps address", 64'(s_adr),
        64'({3'd1, 27'h123}));
    chk(s_cyc == 3'b010, "R3", "owner keeps slave", 64'(s_cyc), 64'(3'b010));
    @(negedge clk);
    chk(m_ack == 4'b0100, "R6", "ack to owner only", 64'(m_ack), 64'(4'b0100));
    chk(m_dat_r == {2'd1, 3'd1, 27'h123}, "R6", "slave 1 data", 64'(m_dat_r),
        64'({2'd1, 3'd1, 27'h123}));
    drop(2);
    begin
      int w = 0;
      while (!m_ack[0] && w < 10) begin @(negedge clk); w++; end
      chk(m_ack == 4'b0001, "R2", "waiting master served next", 64'(m_ack), 64'(1));
      chk(m_dat_r == {2'd0, 3'd0, 27'h777}, "R6", "slave 0 data", 64'(m_dat_r),
          64'({2'd0, 3'd0, 27'h777}));
    end
    drop(0);

    // R4 unmapped segments 2 and 5
    @(negedge clk);
    set_master(1, 3'd2, 27'h42, 1'b1, 32'hDEAD, 4'hF);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(s_cyc == 0 && m_ack == 0, "R4", "segment 2 unmapped", 64'({s_cyc, m_ack}), 64'(0));
    end
    chk(s_adr[29:27] == 3'd2, "R4", "segment 2 on shared bus", 64'(s_adr[29:27]), 64'(2));
    drop(1);
    @(negedge clk);
    set_master(3, 3'd5, 27'h43, 1'b0, 32'h0, 4'hF);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(s_cyc == 0 && m_ack == 0, "R4", "segment 5 unmapped", 64'({s_cyc, m_ack}), 64'(0));
    end
    drop(3);
    mdl_last = 3;
    run_round(4'b0101);   // bus still usable afterwards

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule